// File: doc/BRIEF.md
# Register-File OR Execution Slice

This block executes one instruction: the bitwise OR of an 8-bit working register with a byte chosen from a 256-entry register file. A 16-bit instruction word carries a 7-bit opcode, a destination-select bit and an 8-bit register address. The result lands either in the working register or back in the addressed register, and a zero flag records whether the result was zero. Words that carry any other opcode retire as no-operations.

Each instruction occupies one instruction cycle of four clocks, driven by a free-running internal phase counter. In phase 1 the word is taken, in phase 2 the addressed register is read, in phase 3 the OR is formed, and in phase 4 the destination and flag are written. The word arrives on a valid/ready input. Ready is high only in phase 1. A producer holds its word and valid steady until it sees ready high at a clock edge with valid high, and the word is taken at that edge. A word offered while ready is low is not taken and may be withdrawn. If no word is taken in phase 1, that instruction cycle is idle. No back-pressure exists on the output side. The working register and flag are plain outputs, and a combinational debug port reads any register-file entry.

Reset returns the phase counter to phase 1 and clears the working register and flag. It also loads the register file with a computed pattern so that a system with no other write path still holds distinct data.

Top module: `orx_slice`

## Requirements
- R1: While reset is asserted and directly after it, `in_ready` is 1, `wreg_o` is 0, `zero_o` is 0, and register i holds (37·i + 19) mod 256.
- R2: Only a word whose bits [15:9] equal 7'b0000100 is executed. Any other accepted word leaves the working register, the zero flag and every register unchanged.
- R3: With bit 8 = 0, the working register becomes (working register OR register f), and register f is unchanged. f is bits [7:0].
- R4: With bit 8 = 1, register f becomes (working register OR register f), and the working register is unchanged.
- R5: An executed instruction sets `zero_o` when its 8-bit result is zero and clears it otherwise, for either destination.
- R6: `in_ready` is high in exactly one clock of every four. A word is taken on a clock edge with valid and ready both high. Its outputs change on the fourth clock edge counted from that edge, and they hold their previous values before then.
- R7: A word presented while `in_ready` is low is never executed, even if it is withdrawn before the next phase 1.
- R8: A register written by one instruction is read with its new value by the next instruction's phase-2 read.
- R9: `dbg_data` shows register `dbg_addr` combinationally, including a value written on the preceding edge.
- R10: With register f = 0x13, working register = 0x91 and bit 8 = 0, the working register becomes 0x93 and register f stays 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Slice can take a word (phase 1) |
| in_word | input | 16 | Instruction word |
| wreg_o | output | 8 | Working register |
| zero_o | output | 1 | Zero flag |
| dbg_addr | input | 8 | Debug read address into the register file |
| dbg_data | output | 8 | Debug read data |

## Verification
A corrupted operand latch, result latch or destination bit becomes visible at the ports four clocks after the word is taken. It shows up either on `wreg_o` or through the debug port on register f, and `zero_o` disagrees with the result in that same clock. A phase counter that drifts shows up at once as `in_ready` out of its one-in-four rhythm, or as outputs that move before the fourth edge. A register-file write that lands late or at the wrong address is caught by the next instruction's read or by the debug read taken in the clock after retirement.

// File: rtl/orx_pkg.sv
package orx_pkg;
  typedef enum logic [1:0] {
    PH_DEC = 2'd0,
    PH_RD  = 2'd1,
    PH_EX  = 2'd2,
    PH_WB  = 2'd3
  } phase_e;

  localparam int unsigned OR_OPCODE = 4;
endpackage

// File: rtl/orx_phase.sv
module orx_phase
  import orx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_DEC;
    else        ph <= phase_e'(2'(ph + 2'd1));
  end

  // R6: the write phase is always followed by the decode phase
  a_r6_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WB) |=> (ph == PH_DEC));
endmodule

// File: rtl/orx_decode.sv
module orx_decode #(
  parameter int IW     = 16,
  parameter int AW     = 8,
  parameter int OPCODE = 4
) (
  input  logic [IW-1:0] word,
  output logic          hit,
  output logic          dst,
  output logic [AW-1:0] addr
);
  localparam int OPW = IW - AW - 1;

  assign hit  = (word[IW-1 -: OPW] == OPW'(OPCODE));
  assign dst  = word[AW];
  assign addr = word[AW-1:0];
endmodule

// File: rtl/orx_regfile.sv
module orx_regfile #(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int INIT_MUL = 37,
  parameter int INIT_ADD = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] daddr,
  output logic [DW-1:0] ddata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i * INIT_MUL + INIT_ADD);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign ddata = mem[daddr];

  // R8: a write is present in the array on the following clock
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/orx_slice.sv
module orx_slice
  import orx_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int INIT_MUL = 37,
  parameter int INIT_ADD = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW+7:0]     in_word,
  output logic [DW-1:0]     wreg_o,
  output logic              zero_o,
  input  logic [AW-1:0]     dbg_addr,
  output logic [DW-1:0]     dbg_data
);
  localparam int IW = AW + 8;

  phase_e        ph;
  logic          dec_hit, dec_dst;
  logic [AW-1:0] dec_addr;
  logic          act, ir_dst;
  logic [AW-1:0] ir_addr;
  logic [DW-1:0] opnd, res, rf_rdata;
  logic          take, rf_we;

  orx_phase u_phase (.clk(clk), .rst_n(rst_n), .ph(ph));

  orx_decode #(.IW(IW), .AW(AW), .OPCODE(OR_OPCODE)) u_dec (
    .word(in_word), .hit(dec_hit), .dst(dec_dst), .addr(dec_addr));

  assign in_ready = (ph == PH_DEC);
  assign take     = in_valid && in_ready;
  assign rf_we    = (ph == PH_WB) && act && ir_dst;

  orx_regfile #(.DW(DW), .AW(AW), .INIT_MUL(INIT_MUL), .INIT_ADD(INIT_ADD)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(ir_addr), .wdata(res),
    .raddr(ir_addr), .rdata(rf_rdata),
    .daddr(dbg_addr), .ddata(dbg_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      ir_dst  <= 1'b0;
      ir_addr <= '0;
      opnd    <= '0;
      res     <= '0;
      wreg_o  <= '0;
      zero_o  <= 1'b0;
    end else begin
      unique case (ph)
        PH_DEC: begin
          act <= take && dec_hit;
          if (take) begin
            ir_dst  <= dec_dst;
            ir_addr <= dec_addr;
          end
        end
        PH_RD: opnd <= rf_rdata;
        PH_EX: res  <= opnd | wreg_o;
        PH_WB: begin
          if (act) begin
            if (!ir_dst) wreg_o <= res;
            zero_o <= (res == '0);
          end
          act <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R6: after a word is taken, ready stays low for three clocks, then returns
  a_r6_accept_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready ##1 !in_ready ##1 !in_ready ##1 in_ready);

  // R6: the working register moves only on the phase-4 edge
  a_r6_wreg_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wreg_o) |-> ($past(ph) == PH_WB));

  // R4: a write-back to the register file leaves the working register alone
  a_r4_wreg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WB && act && ir_dst) |=> $stable(wreg_o));

  // R5: with the working register as destination, the flag mirrors it
  a_r5_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WB && act && !ir_dst) |=> (zero_o == (wreg_o == '0)));

  // R2: an idle or non-matching cycle changes neither output
  a_r2_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WB && !act) |=> ($stable(wreg_o) && $stable(zero_o)));
endmodule

// File: tb/orx_slice_test.sv
module orx_slice_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [7:0]  wreg_o;
  logic        zero_o;
  logic [7:0]  dbg_addr = '0;
  logic [7:0]  dbg_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_w;
  logic       m_z;

  always #(PERIOD/2) clk = ~clk;

  orx_slice uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .wreg_o(wreg_o), .zero_o(zero_o),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 19) & 255);
  endfunction

  // reset and, while held, sweep every register through the debug port (R1)
  task automatic do_reset(input bit sweep);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) m_mem[i] = init_val(i);
    m_w = '0;
    m_z = 1'b0;
    check("R1", in_ready, 1);
    check("R1", wreg_o, 0);
    check("R1", zero_o, 0);
    if (sweep) begin
      for (int i = 0; i < 256; i++) begin
        dbg_addr = 8'(i);
        #1;
        check("R1", dbg_data, m_mem[i]);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present one word in phase 1, follow it through to retirement
  task automatic run_op(input logic [6:0] op, input logic d, input logic [7:0] f, input string tag);
    logic [7:0] w_before;
    logic [7:0] r;
    w_before = m_w;
    check("R6", in_ready, 1);
    in_word  = {op, d, f};
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = '0;
    check("R6", in_ready, 0);
    check("R6", wreg_o, w_before);
    @(posedge clk);
    @(negedge clk);
    check("R6", in_ready, 0);
    check("R6", wreg_o, w_before);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (op == 7'b0000100) begin
      r = m_w | m_mem[f];
      if (d) m_mem[f] = r;
      else   m_w = r;
      m_z = (r == 8'h00);
    end
    check(tag, wreg_o, m_w);
    check(tag, zero_o, m_z);
    dbg_addr = f;
    #1;
    check(tag, dbg_data, m_mem[f]);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state and initial pattern
    do_reset(1'b1);

    // R10 worked example: register 38 holds 0x91, register 0 holds 0x13
    run_op(7'd4, 1'b0, 8'd38, "R10");
    run_op(7'd4, 1'b0, 8'd0, "R10");
    check("R10", wreg_o, 8'h93);
    dbg_addr = 8'd0;
    #1;
    check("R10", dbg_data, 8'h13);

    // R5 zero result to either destination: register 41 holds 0
    do_reset(1'b0);
    run_op(7'd4, 1'b0, 8'd41, "R5");
    check("R5", zero_o, 1);
    run_op(7'd4, 1'b1, 8'd41, "R5");
    check("R5", zero_o, 1);
    run_op(7'd4, 1'b0, 8'd1, "R5");
    check("R5", zero_o, 0);

    // R3 R4 R8 sweep over every address from a clean state
    for (int f = 0; f < 256; f++) begin
      do_reset(1'b0);
      run_op(7'd4, 1'b1, 8'(f), "R4");
      run_op(7'd4, 1'b0, 8'(f), "R3");
      run_op(7'd4, 1'b1, 8'(f + 1), "R4");
      run_op(7'd4, 1'b0, 8'(f + 1), "R8");
      run_op(7'd4, 1'b1, 8'(f + 7), "R4");
      dbg_addr = 8'(f + 7);
      #1;
      check("R9", dbg_data, m_mem[8'(f + 7)]);
    end

    // R2 every other opcode, destination both ways, is a no-operation
    do_reset(1'b0);
    run_op(7'd4, 1'b0, 8'd5, "R3");
    for (int op = 0; op < 128; op++) begin
      if (op != 4) begin
        run_op(7'(op), op[0], 8'(op * 3 + 41), "R2");
      end
    end

    // R7 a word offered only while ready is low is never executed
    do_reset(1'b0);
    run_op(7'd4, 1'b0, 8'd38, "R3");
    check("R7", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    check("R7", in_ready, 0);
    in_word  = {7'd4, 1'b1, 8'd41};
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = '0;
    @(posedge clk);
    @(negedge clk);
    check("R7", in_ready, 1);
    check("R7", wreg_o, 8'h91);
    check("R7", zero_o, m_z);
    dbg_addr = 8'd41;
    #1;
    check("R7", dbg_data, 8'h00);
    run_op(7'd4, 1'b0, 8'd41, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule